// File: doc/BRIEF.md
# Layer-Multiplexed Neural Network Sequencer

This block is the global sequencer for a forward pass through a layered network. It drives a pool of 16 multiply-accumulate neurons that all act in lockstep. The same pool is reused for every layer. A LOAD command fetches a small topology record from the weight memory: a layer count and the node count of each layer, with layer 0 being the network inputs. A RUN command then walks the network one layer at a time. For each input of a layer it reads one activation from the state memory and broadcasts it. It fetches one weight for each active neuron, then strobes all active neurons at once. A bias term closes each layer. After that, each neuron's sum is placed in turn on a shared readout, converted to a lookup address, passed through an external sigmoid ROM, and written back to the state memory as an activation for the next layer.

The state memory, the weight memory and the sigmoid ROM sit outside the block. All three are synchronous: data appears in the cycle after the read strobe. The active-low `busy_n` output is high only while the sequencer is idle and ready for a command.

Top module: `nnseq_top`

## Requirements
- R1: After reset `busy_n` is 1 and no memory read, memory write or ROM read is issued.
- R2: A LOAD command in idle pulls `busy_n` low in the next cycle and reads weight address 0 (the layer count L, clamped to 8) and then addresses 1..L (the node count of layer 0..L-1, clamped to 1..16). It performs no state write, then returns to idle.
- R3: A RUN command in idle after a LOAD pulls `busy_n` low in the next cycle and computes layers 1..L-1 in order. When the last write-back is done, `busy_n` returns to 1.
- R4: Weights are read from consecutive addresses starting at L+1 and running without gaps across the whole pass. For each input i of a layer in ascending order, with the bias last, one weight is read for each output neuron j in ascending order.
- R5: Layer 1 reads its activations from state address 0. Each later layer reads from the first address of the previous layer's outputs. The outputs of a layer are written at consecutive addresses directly after the activations that layer read.
- R6: Neuron j's sum is the sum of sign-extended 16-bit weight times activation products, plus its bias weight times 0x7FFF. The ROM address is that sum arithmetically shifted right by 21 and saturated to [-512, 511], sent as 10-bit two's complement. The value written for neuron j is the 10-bit ROM word followed by six zero bits. Writes go out in ascending j.
- R7: A RUN before any LOAD is ignored: `busy_n` stays 1 and no memory access occurs.
- R8: RUN or LOAD commands that arrive while `busy_n` is 0 are ignored, and the pass in progress completes unchanged.
- R9: A layer with fewer than 16 nodes keeps the unused neurons inactive and writes back exactly its own node count of results.
- R10: A further RUN without a new LOAD repeats the pass on the stored topology, using the current state memory inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_cmd | input | 1 | Fetch topology (one-cycle pulse) |
| run_cmd | input | 1 | Start forward pass (one-cycle pulse) |
| busy_n | output | 1 | High when idle and ready |
| wt_rd | output | 1 | Weight memory read strobe |
| wt_addr | output | 11 | Weight memory address |
| wt_rdata | input | 16 | Weight memory data, valid one cycle after strobe |
| st_rd | output | 1 | State memory read strobe |
| st_wr | output | 1 | State memory write strobe |
| st_addr | output | 6 | State memory address |
| st_wdata | output | 16 | State memory write data |
| st_rdata | input | 16 | State memory data, valid one cycle after strobe |
| lut_rd | output | 1 | Sigmoid ROM read strobe |
| lut_addr | output | 10 | Sigmoid ROM address |
| lut_rdata | input | 10 | Sigmoid ROM data, valid one cycle after strobe |

## Verification
A wrong internal state shows up quickly in the values written back. A skipped or repeated weight fetch shifts every later product. A wrong read or write base moves the results to the wrong addresses. A neuron that stays active beyond its layer size adds stray writes. The first such error appears as a write-back mismatch at the end of the affected layer, within a few dozen cycles. Later layers then inherit the error. Command-filtering faults show up at once as a `busy_n` change or as memory traffic where none is allowed.

// File: rtl/nnseq_pkg.sv
package nnseq_pkg;

    localparam int unsigned NUM_NEURONS = 16;
    localparam int unsigned DATA_W      = 16;
    localparam int unsigned ACC_W       = 40;
    localparam int unsigned LUT_W       = 10;
    localparam int unsigned SADDR_W     = 6;
    localparam int unsigned WADDR_W     = 11;
    localparam int unsigned MAX_LAYERS  = 8;
    localparam int unsigned SUM_SHIFT   = 21;

    typedef enum logic [3:0] {
        S_IDLE,
        S_TREQ,
        S_TCAP,
        S_CLR,
        S_ACT,
        S_WT,
        S_WDRN,
        S_MAC,
        S_OUT,
        S_ODRN
    } seq_state_e;

endpackage

// File: rtl/nnseq_neuron_pool.sv
module nnseq_neuron_pool #(
    parameter int unsigned N  = nnseq_pkg::NUM_NEURONS,
    parameter int unsigned DW = nnseq_pkg::DATA_W,
    parameter int unsigned AW = nnseq_pkg::ACC_W,
    localparam int unsigned IW = $clog2(N),
    localparam int unsigned CW = $clog2(N) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          wload,
    input  logic [IW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic          mac,
    input  logic [DW-1:0] act,
    input  logic [CW-1:0] n_active,
    input  logic [IW-1:0] sel,
    output logic [AW-1:0] sum_sel
);

    logic [AW-1:0] acc_arr [N];

    for (genvar g = 0; g < N; g++) begin : g_nrn
        logic [DW-1:0]          wreg;
        logic [AW-1:0]          acc;
        logic signed [2*DW-1:0] prod;
        logic                   active;

        assign active = (CW'(g) < n_active);
        assign prod   = $signed(wreg) * $signed(act);

        always_ff @(posedge clk) begin
            if (rst) begin
                wreg <= '0;
                acc  <= '0;
            end else begin
                if (wload && widx == IW'(g)) wreg <= wdata;
                if (clr) acc <= '0;
                else if (mac && active)
                    acc <= acc + {{(AW-2*DW){prod[2*DW-1]}}, prod};
            end
        end

        assign acc_arr[g] = acc;

        AST_IDLE_HELD: assert property (@(posedge clk) disable iff (rst)
            (mac && !clr && !active) |=> $stable(acc)); // R9
    end

    assign sum_sel = acc_arr[sel];

endmodule

// File: rtl/nnseq_squash.sv
module nnseq_squash #(
    parameter int unsigned AW    = nnseq_pkg::ACC_W,
    parameter int unsigned LW    = nnseq_pkg::LUT_W,
    parameter int unsigned SHIFT = nnseq_pkg::SUM_SHIFT
) (
    input  logic [AW-1:0] sum_i,
    output logic [LW-1:0] addr_o
);

    localparam logic signed [AW-1:0] LMAX = AW'((2 ** (LW - 1)) - 1);
    localparam logic signed [AW-1:0] LMIN = ~LMAX;

    logic signed [AW-1:0] sh;

    always_comb begin
        sh = $signed(sum_i) >>> SHIFT;
        if (sh > LMAX)      addr_o = LMAX[LW-1:0];
        else if (sh < LMIN) addr_o = LMIN[LW-1:0];
        else                addr_o = sh[LW-1:0];
    end

endmodule

// File: rtl/nnseq_ctrl.sv
module nnseq_ctrl
    import nnseq_pkg::*;
#(
    parameter int unsigned N     = NUM_NEURONS,
    parameter int unsigned DW    = DATA_W,
    parameter int unsigned LW    = LUT_W,
    parameter int unsigned SAW   = SADDR_W,
    parameter int unsigned WAW   = WADDR_W,
    parameter int unsigned MAX_L = MAX_LAYERS,
    localparam int unsigned IW   = $clog2(N),
    localparam int unsigned CW   = $clog2(N) + 1,
    localparam int unsigned LCW  = $clog2(MAX_L + 1),
    localparam int unsigned LIW  = $clog2(MAX_L)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load_cmd,
    input  logic           run_cmd,
    output logic           busy_n,
    output logic           wt_rd,
    output logic [WAW-1:0] wt_addr,
    input  logic [DW-1:0]  wt_rdata,
    output logic           st_rd,
    output logic           st_wr,
    output logic [SAW-1:0] st_addr,
    output logic [DW-1:0]  st_wdata,
    input  logic [DW-1:0]  st_rdata,
    output logic           lut_rd,
    input  logic [LW-1:0]  lut_rdata,
    output logic           p_clr,
    output logic           p_wload,
    output logic [IW-1:0]  p_widx,
    output logic           p_mac,
    output logic [DW-1:0]  p_act,
    output logic [CW-1:0]  p_nact,
    output logic [IW-1:0]  p_sel
);

    localparam logic [DW-1:0] BIAS_ONE = {1'b0, {(DW-1){1'b1}}};

    seq_state_e     state;
    logic           loaded;
    logic [LCW-1:0] n_layers;
    logic [CW-1:0]  lsz [MAX_L];
    logic [LCW-1:0] tidx, layer;
    logic [CW-1:0]  in_i, nj;
    logic [SAW-1:0] rd_base, wr_base;
    logic [WAW-1:0] wptr;
    logic [DW-1:0]  act_q;
    logic           wl_valid, wb_valid;
    logic [CW-1:0]  wl_idx, wb_idx;

    logic [LCW-1:0] tm1, lm1, cnt_new, cnt_now;
    logic [CW-1:0]  n_in, n_out, sz_new;
    logic           in_real;

    assign tm1     = tidx - LCW'(1);
    assign lm1     = layer - LCW'(1);
    assign n_in    = lsz[lm1[LIW-1:0]];
    assign n_out   = lsz[layer[LIW-1:0]];
    assign in_real = (in_i < n_in);

    always_comb begin
        if (wt_rdata > DW'(MAX_L)) cnt_new = LCW'(MAX_L);
        else                       cnt_new = wt_rdata[LCW-1:0];
        if (wt_rdata > DW'(N))     sz_new = CW'(N);
        else if (wt_rdata == '0)   sz_new = CW'(1);
        else                       sz_new = wt_rdata[CW-1:0];
        cnt_now = (tidx == '0) ? cnt_new : n_layers;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            loaded   <= 1'b0;
            n_layers <= '0;
            for (int k = 0; k < int'(MAX_L); k++) lsz[k] <= CW'(1);
            tidx     <= '0;
            layer    <= '0;
            in_i     <= '0;
            nj       <= '0;
            rd_base  <= '0;
            wr_base  <= '0;
            wptr     <= '0;
            act_q    <= '0;
            wl_valid <= 1'b0;
            wl_idx   <= '0;
            wb_valid <= 1'b0;
            wb_idx   <= '0;
        end else begin
            wl_valid <= (state == S_WT);
            wl_idx   <= nj;
            wb_valid <= (state == S_OUT);
            wb_idx   <= nj;
            case (state)
                S_IDLE: begin
                    if (load_cmd) begin
                        tidx  <= '0;
                        state <= S_TREQ;
                    end else if (run_cmd && loaded && n_layers >= LCW'(2)) begin
                        layer   <= LCW'(1);
                        rd_base <= '0;
                        wr_base <= SAW'(lsz[0]);
                        wptr    <= WAW'(n_layers) + WAW'(1);
                        state   <= S_CLR;
                    end
                end
                S_TREQ: state <= S_TCAP;
                S_TCAP: begin
                    if (tidx == '0) n_layers <= cnt_new;
                    else            lsz[tm1[LIW-1:0]] <= sz_new;
                    if (tidx >= cnt_now) begin
                        loaded <= 1'b1;
                        state  <= S_IDLE;
                    end else begin
                        tidx  <= tidx + LCW'(1);
                        state <= S_TREQ;
                    end
                end
                S_CLR: begin
                    in_i  <= '0;
                    state <= S_ACT;
                end
                S_ACT: begin
                    nj    <= '0;
                    state <= S_WT;
                end
                S_WT: begin
                    wptr <= wptr + WAW'(1);
                    if (nj == '0) act_q <= in_real ? st_rdata : BIAS_ONE;
                    nj <= nj + CW'(1);
                    if (nj == n_out - CW'(1)) state <= S_WDRN;
                end
                S_WDRN: state <= S_MAC;
                S_MAC: begin
                    if (in_i == n_in) begin
                        nj    <= '0;
                        state <= S_OUT;
                    end else begin
                        in_i  <= in_i + CW'(1);
                        state <= S_ACT;
                    end
                end
                S_OUT: begin
                    nj <= nj + CW'(1);
                    if (nj == n_out - CW'(1)) state <= S_ODRN;
                end
                S_ODRN: begin
                    if (layer + LCW'(1) >= n_layers) begin
                        state <= S_IDLE;
                    end else begin
                        layer   <= layer + LCW'(1);
                        rd_base <= wr_base;
                        wr_base <= wr_base + SAW'(n_out);
                        state   <= S_CLR;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign busy_n   = (state == S_IDLE);
    assign wt_rd    = (state == S_TREQ) || (state == S_WT);
    assign wt_addr  = (state == S_TREQ) ? WAW'(tidx) : wptr;
    assign st_rd    = (state == S_ACT) && in_real;
    assign st_wr    = wb_valid;
    assign st_addr  = wb_valid ? (wr_base + SAW'(wb_idx)) : (rd_base + SAW'(in_i));
    assign st_wdata = {lut_rdata, {(DW-LW){1'b0}}};
    assign lut_rd   = (state == S_OUT);
    assign p_clr    = (state == S_CLR);
    assign p_wload  = wl_valid;
    assign p_widx   = wl_idx[IW-1:0];
    assign p_mac    = (state == S_MAC);
    assign p_act    = act_q;
    assign p_nact   = n_out;
    assign p_sel    = nj[IW-1:0];

    // checker state: last weight address fetched during a pass
    logic [WAW-1:0] wlast;
    logic           wseen;
    always_ff @(posedge clk) begin
        if (rst) begin
            wlast <= '0;
            wseen <= 1'b0;
        end else if (state == S_IDLE) begin
            wseen <= 1'b0;
        end else if (state == S_WT) begin
            wlast <= wt_addr;
            wseen <= 1'b1;
        end
    end

    AST_WT_SEQUENTIAL: assert property (@(posedge clk) disable iff (rst)
        (state == S_WT && wseen) |-> (wt_addr == wlast + WAW'(1))); // R4
    AST_RUN_UNLOADED: assert property (@(posedge clk) disable iff (rst)
        (busy_n && !loaded && run_cmd && !load_cmd) |=> busy_n); // R7
    AST_LOAD_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy_n && load_cmd) |=> !busy_n); // R2
    AST_WB_AFTER_LUT: assert property (@(posedge clk) disable iff (rst)
        st_wr |-> $past(lut_rd)); // R6

endmodule

// File: rtl/nnseq_top.sv
module nnseq_top
    import nnseq_pkg::*;
#(
    parameter int unsigned N     = NUM_NEURONS,
    parameter int unsigned DW    = DATA_W,
    parameter int unsigned AW    = ACC_W,
    parameter int unsigned LW    = LUT_W,
    parameter int unsigned SAW   = SADDR_W,
    parameter int unsigned WAW   = WADDR_W,
    parameter int unsigned MAX_L = MAX_LAYERS,
    parameter int unsigned SHIFT = SUM_SHIFT
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load_cmd,
    input  logic           run_cmd,
    output logic           busy_n,
    output logic           wt_rd,
    output logic [WAW-1:0] wt_addr,
    input  logic [DW-1:0]  wt_rdata,
    output logic           st_rd,
    output logic           st_wr,
    output logic [SAW-1:0] st_addr,
    output logic [DW-1:0]  st_wdata,
    input  logic [DW-1:0]  st_rdata,
    output logic           lut_rd,
    output logic [LW-1:0]  lut_addr,
    input  logic [LW-1:0]  lut_rdata
);

    localparam int unsigned IW = $clog2(N);
    localparam int unsigned CW = $clog2(N) + 1;

    logic          p_clr, p_wload, p_mac;
    logic [IW-1:0] p_widx, p_sel;
    logic [DW-1:0] p_act;
    logic [CW-1:0] p_nact;
    logic [AW-1:0] sum_sel;

    nnseq_ctrl #(
        .N(N), .DW(DW), .LW(LW), .SAW(SAW), .WAW(WAW), .MAX_L(MAX_L)
    ) u_ctrl (
        .clk(clk), .rst(rst), .load_cmd(load_cmd), .run_cmd(run_cmd),
        .busy_n(busy_n), .wt_rd(wt_rd), .wt_addr(wt_addr), .wt_rdata(wt_rdata),
        .st_rd(st_rd), .st_wr(st_wr), .st_addr(st_addr), .st_wdata(st_wdata),
        .st_rdata(st_rdata), .lut_rd(lut_rd), .lut_rdata(lut_rdata),
        .p_clr(p_clr), .p_wload(p_wload), .p_widx(p_widx), .p_mac(p_mac),
        .p_act(p_act), .p_nact(p_nact), .p_sel(p_sel)
    );

    nnseq_neuron_pool #(.N(N), .DW(DW), .AW(AW)) u_pool (
        .clk(clk), .rst(rst), .clr(p_clr), .wload(p_wload), .widx(p_widx),
        .wdata(wt_rdata), .mac(p_mac), .act(p_act), .n_active(p_nact),
        .sel(p_sel), .sum_sel(sum_sel)
    );

    nnseq_squash #(.AW(AW), .LW(LW), .SHIFT(SHIFT)) u_squash (
        .sum_i(sum_sel), .addr_o(lut_addr)
    );

endmodule

// File: tb/tb_nnseq_top.sv
`timescale 1ns/1ps
module tb_nnseq_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_cmd = 1'b0, run_cmd = 1'b0;
    logic        busy_n, wt_rd, st_rd, st_wr, lut_rd;
    logic [10:0] wt_addr;
    logic [15:0] wt_rdata = '0, st_rdata = '0, st_wdata;
    logic [5:0]  st_addr;
    logic [9:0]  lut_addr, lut_rdata = '0;

    always #2 clk = ~clk;

    nnseq_top dut (
        .clk(clk), .rst(rst), .load_cmd(load_cmd), .run_cmd(run_cmd),
        .busy_n(busy_n), .wt_rd(wt_rd), .wt_addr(wt_addr), .wt_rdata(wt_rdata),
        .st_rd(st_rd), .st_wr(st_wr), .st_addr(st_addr), .st_wdata(st_wdata),
        .st_rdata(st_rdata), .lut_rd(lut_rd), .lut_addr(lut_addr),
        .lut_rdata(lut_rdata)
    );

    logic [15:0] wmem [2048];
    logic [15:0] smem [64];

    function automatic logic [9:0] lut_f(input logic [9:0] a);
        return {a[9], a[9:1]} + 10'd3;
    endfunction

    always @(posedge clk) begin
        if (wt_rd)  wt_rdata  <= wmem[wt_addr];
        if (st_rd)  st_rdata  <= smem[st_addr];
        if (st_wr)  smem[st_addr] <= st_wdata;
        if (lut_rd) lut_rdata <= lut_f(lut_addr);
    end

    int checks = 0, failures = 0;
    int cyc = 0;
    logic timeout = 1'b0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) timeout <= 1'b1;
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // scoreboard
    logic [21:0] exp_q [$];
    int n_wr = 0, n_wtrd = 0, n_strd = 0, n_lut = 0;
    logic        run_mode = 1'b0;
    int          exp_waddr = 0, waddr_err = 0;

    always @(negedge clk) begin
        if (wt_rd) n_wtrd++;
        if (st_rd) n_strd++;
        if (lut_rd) n_lut++;
        if (wt_rd && run_mode) begin
            if (int'(wt_addr) != exp_waddr) waddr_err++;
            exp_waddr++;
        end
        if (st_wr) begin
            n_wr++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 unexpected write", int'(st_addr), -1);
            end else begin
                logic [21:0] e;
                e = exp_q.pop_front();
                check(st_addr == e[21:16], "R5 write address", int'(st_addr), int'(e[21:16]));
                check(st_wdata == e[15:0], "R6 write data", int'(st_wdata), int'(e[15:0]));
            end
        end
    end

    int unsigned seed = 32'h1234_5678;
    function automatic logic [15:0] rnd_val(input int mag);
        int r;
        seed = seed * 32'd1103515245 + 32'd12345;
        r = int'((seed >> 8) % unsigned'(2 * mag + 1)) - mag;
        return 16'(r);
    endfunction

    int tl;
    int tsz [8];

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wait_idle();
        while (!busy_n && !timeout) @(negedge clk);
    endtask

    task automatic do_load(input int l, input int s0, input int s1, input int s2, input int s3);
        int nw, wr0;
        tl = l; tsz[0] = s0; tsz[1] = s1; tsz[2] = s2; tsz[3] = s3;
        wmem[0] = 16'(l);
        for (int k = 0; k < l; k++) wmem[k+1] = 16'(tsz[k]);
        nw = 0;
        for (int k = 1; k < l; k++) nw += (tsz[k-1] + 1) * tsz[k];
        for (int k = 0; k < nw; k++) wmem[l+1+k] = rnd_val(12000);
        n_wtrd = 0; wr0 = n_wr;
        load_cmd = 1'b1; @(negedge clk); load_cmd = 1'b0;
        check(busy_n == 1'b0, "R2 busy low during load", int'(busy_n), 0);
        wait_idle();
        check(n_wtrd == l + 1, "R2 topology reads", n_wtrd, l + 1);
        check(n_wr == wr0, "R2 no state writes on load", n_wr - wr0, 0);
    endtask

    task automatic set_inputs();
        for (int k = 0; k < tsz[0]; k++) smem[k] = rnd_val(16000);
    endtask

    task automatic predict(output int nexp);
        logic [15:0] m [64];
        longint acc [16];
        int rb, wb, wp;
        for (int k = 0; k < 64; k++) m[k] = smem[k];
        rb = 0; wb = tsz[0]; wp = tl + 1; nexp = 0;
        for (int k = 1; k < tl; k++) begin
            int nin, nout;
            nin = tsz[k-1]; nout = tsz[k];
            for (int j = 0; j < 16; j++) acc[j] = 0;
            for (int i = 0; i <= nin; i++) begin
                longint a;
                a = (i < nin) ? longint'($signed(m[rb+i])) : 64'sd32767;
                for (int j = 0; j < nout; j++) begin
                    acc[j] += longint'($signed(wmem[wp])) * a;
                    wp++;
                end
            end
            for (int j = 0; j < nout; j++) begin
                longint sh;
                logic [15:0] d;
                sh = acc[j] >>> 21;
                if (sh > 511) sh = 511;
                if (sh < -512) sh = -512;
                d = {lut_f(10'(sh)), 6'b0};
                m[wb+j] = d;
                exp_q.push_back({6'(wb + j), d});
                nexp++;
            end
            rb = wb; wb = wb + nout;
        end
    endtask

    task automatic do_run(input logic disturb);
        int nexp, wr0;
        predict(nexp);
        wr0 = n_wr; waddr_err = 0; exp_waddr = tl + 1; run_mode = 1'b1;
        run_cmd = 1'b1; @(negedge clk); run_cmd = 1'b0;
        check(busy_n == 1'b0, "R3 busy low during run", int'(busy_n), 0);
        if (disturb) begin
            tick(10);
            run_cmd = 1'b1; load_cmd = 1'b1; @(negedge clk);
            run_cmd = 1'b0; load_cmd = 1'b0;
            check(busy_n == 1'b0, "R8 command while busy ignored", int'(busy_n), 0);
        end
        wait_idle();
        run_mode = 1'b0;
        check(busy_n == 1'b1, "R3 busy high after pass", int'(busy_n), 1);
        check(n_wr - wr0 == nexp, "R9 write count equals layer sizes", n_wr - wr0, nexp);
        check(exp_q.size() == 0, "R6 all expected writes seen", exp_q.size(), 0);
        check(waddr_err == 0, "R4 weight address order", waddr_err, 0);
        exp_q.delete();
    endtask

    initial begin
        for (int k = 0; k < 2048; k++) wmem[k] = '0;
        for (int k = 0; k < 64; k++) smem[k] = '0;
        tick(3);
        rst = 1'b0;
        @(negedge clk);
        check(busy_n == 1'b1, "R1 busy_n after reset", int'(busy_n), 1);
        check(!wt_rd && !st_rd && !st_wr && !lut_rd, "R1 no access after reset",
              int'({wt_rd, st_rd, st_wr, lut_rd}), 0);

        // R7: run before any load
        n_wtrd = 0; n_strd = 0; n_lut = 0;
        run_cmd = 1'b1; @(negedge clk); run_cmd = 1'b0;
        tick(10);
        check(busy_n == 1'b1, "R7 run before load keeps busy_n high", int'(busy_n), 1);
        check(n_wtrd + n_strd + n_lut + n_wr == 0, "R7 no access on ignored run",
              n_wtrd + n_strd + n_lut + n_wr, 0);

        // first topology 4-5-3, smaller second layer (R9)
        do_load(3, 4, 5, 3, 0);
        set_inputs();
        do_run(1'b0);                 // R3 R4 R5 R6
        set_inputs();
        do_run(1'b1);                 // R8 with disturbing commands, R10 reuse
        set_inputs();
        do_run(1'b0);                 // R10 again, no reload

        // second topology 3-16-2-1, full pool then narrow layers
        do_load(4, 3, 16, 2, 1);
        set_inputs();
        do_run(1'b0);                 // R5 multi-layer bases, R9
        for (int k = 0; k < 3; k++) smem[k] = (k == 0) ? 16'h7FFF : 16'h8000;
        do_run(1'b0);                 // R6 saturation-heavy inputs

        if (timeout) begin
            checks++; failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait (timeout);
        tick(2);
        checks++; failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule